// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is a serial-bus target for the 100 kHz standard-mode two-wire bus. It gives an external master access to a register space with 16-bit addresses and 16-bit data. SCL and SDA are oversampled by the system clock. Both lines are resynchronised and glitch-filtered before START, STOP and clock edges are detected. The block drives SDA only through an open-drain pull-down enable.

A master can do three things. It can load the 16-bit register pointer. It can write one register, which first loads the pointer with the target address. It can read the register the pointer currently selects. Addresses and data travel most significant byte first. The pointer is kept between transactions, so a read with no address phase returns the register selected last.

On the register side the block presents a plain bus: the pointer, the write data, a one-cycle write strobe, a one-cycle read strobe, and a read-data input. The read-data input is captured one cycle after the read strobe. The 7-bit device address is `111000x`, where `x` comes from a strap input.

Top module: `i2cp_target`

## Requirements
- R1: The target answers only to device address `{6'b111000, addr_sel}` and acknowledges a match by pulling SDA low during the ninth SCL clock of the control byte.
- R2: Bit 0 of the control byte selects the direction: 0 means write, 1 means read. A matching read control byte raises `reg_re` for exactly one clock.
- R3: A control byte whose address does not match is not acknowledged. SDA is left released for all later bytes until the next START.
- R4: After a write control byte, the address high byte and the address low byte are each acknowledged. Once the low byte is acknowledged, `reg_addr` equals `{high, low}`.
- R5: When the data high byte and data low byte follow the address bytes, `reg_we` pulses for one clock after the data low byte's acknowledge clock. At that pulse `reg_wdata = {data high, data low}` and `reg_addr` is steady.
- R6: A read sends `reg_rdata` for the current pointer, high byte first and each byte MSB first.
- R7: The pointer persists across transactions. Repeated reads with no address phase return the same register.
- R8: A STOP, or a repeated START, that arrives before the data low byte has been acknowledged produces no `reg_we`. The addressed register keeps its value.
- R9: A pulse on SCL or SDA shorter than three system clocks after synchronisation has no effect on the transfer.
- R10: If the master NACKs a read byte, the target releases SDA for the rest of the transaction. After the data low byte the target always releases SDA.
- R11: In a write, a fifth byte after the control byte is not acknowledged and produces no further `reg_we`.
- R12: After reset `sda_oe`, `reg_we` and `reg_re` are 0 and `reg_addr` is 0. `sda_oe` only ever becomes asserted while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| addr_sel | input | 1 | Strap giving the LSB of the device address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 16 | Current register pointer |
| reg_wdata | output | 16 | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 16 | Register read data, sampled the cycle after `reg_re` |

## Verification
The assertions check four things on every cycle. The two strobes must last exactly one clock and must never coincide. SDA may only begin to be driven while SCL is low. The pointer must be steady while a write strobe is issued. Only the bench's directed scenarios can show the protocol behaviour. That covers address matching under both strap values, pointer persistence, abort by STOP or repeated START, NACK release during reads, the fifth-byte NACK, and the rejection of short glitches, all observed through the bus and the register port.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int SYNC_N   = 2;
    localparam int FILT_N   = 3;
    localparam int WR_BYTES = 4;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int IDX_W    = $clog2(WR_BYTES + 1);

    localparam logic [5:0] DEV_ADDR_HI = 6'b111000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } xfer_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic dev_match(input logic [6:0] addr, input logic sel);
        return addr == {DEV_ADDR_HI, sel};
    endfunction

endpackage

// File: rtl/i2cp_line_filter.sv
module i2cp_line_filter #(
    parameter int   SYNC_N  = 2,
    parameter int   FILT_N  = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [SYNC_N-1:0] sync_q;
    logic [FILT_N-1:0] hist_q;
    logic              level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= {SYNC_N{RST_VAL}};
            hist_q  <= {FILT_N{RST_VAL}};
            level_q <= RST_VAL;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], din};
            hist_q <= {hist_q[FILT_N-2:0], sync_q[SYNC_N-1]};
            if (&hist_q) begin
                level_q <= 1'b1;
            end else if (~|hist_q) begin
                level_q <= 1'b0;
            end
        end
    end

    assign dout = level_q;

endmodule

// File: rtl/i2cp_bus_events.sv
module i2cp_bus_events
    import i2cp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);

    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        evt.start    = scl_f && scl_p && sda_p && !sda_f;
        evt.stop     = scl_f && scl_p && !sda_p && sda_f;
        evt.scl_rise = scl_f && !scl_p;
        evt.scl_fall = !scl_f && scl_p;
        evt.sda      = sda_f;
    end

endmodule

// File: rtl/i2cp_xfer_fsm.sv
module i2cp_xfer_fsm
    import i2cp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              addr_sel,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re
);

    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(WR_BYTES);

    xfer_state_e        state_q;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [IDX_W-1:0]   byte_idx_q;
    logic [BYTE_W-1:0]  shift_q;
    logic [BYTE_W-1:0]  ahi_q;
    logic [BYTE_W-1:0]  dhi_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  tx_q;
    logic               rw_q;
    logic               mack_q;
    logic               oe_q;
    logic               we_q;
    logic               re_q;
    logic               cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
            shift_q    <= '0;
            ahi_q      <= '0;
            dhi_q      <= '0;
            ptr_q      <= '0;
            wdata_q    <= '0;
            tx_q       <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            oe_q       <= 1'b0;
            we_q       <= 1'b0;
            re_q       <= 1'b0;
            cap_q      <= 1'b0;
        end else begin
            we_q  <= 1'b0;
            re_q  <= 1'b0;
            cap_q <= re_q;
            if (cap_q) begin
                tx_q <= reg_rdata;
            end

            if (evt.start) begin
                state_q    <= ST_CTRL;
                bit_cnt_q  <= '0;
                byte_idx_q <= '0;
                oe_q       <= 1'b0;
            end else if (evt.stop) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_CTRL: begin
                        if (evt.scl_rise) begin
                            shift_q   <= {shift_q[BYTE_W-2:0], evt.sda};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (evt.scl_fall && bit_cnt_q == BITS_FULL) begin
                            if (dev_match(shift_q[BYTE_W-1:1], addr_sel)) begin
                                oe_q    <= 1'b1;
                                rw_q    <= shift_q[0];
                                re_q    <= shift_q[0];
                                state_q <= ST_CTRL_ACK;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                    ST_CTRL_ACK: begin
                        if (evt.scl_fall) begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                oe_q    <= ~tx_q[DATA_W-1];
                                state_q <= ST_TX;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= ST_RX;
                            end
                        end
                    end
                    ST_RX: begin
                        if (evt.scl_rise) begin
                            shift_q   <= {shift_q[BYTE_W-2:0], evt.sda};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (evt.scl_fall && bit_cnt_q == BITS_FULL) begin
                            if (byte_idx_q < IDX_LIMIT) begin
                                oe_q    <= 1'b1;
                                state_q <= ST_RX_ACK;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (evt.scl_fall) begin
                            oe_q       <= 1'b0;
                            bit_cnt_q  <= '0;
                            byte_idx_q <= byte_idx_q + 1'b1;
                            state_q    <= ST_RX;
                            case (byte_idx_q)
                                IDX_W'(0): ahi_q <= shift_q;
                                IDX_W'(1): ptr_q <= {ahi_q, shift_q};
                                IDX_W'(2): dhi_q <= shift_q;
                                IDX_W'(3): begin
                                    wdata_q <= {dhi_q, shift_q};
                                    we_q    <= 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_fall) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            tx_q      <= {tx_q[DATA_W-2:0], 1'b0};
                            if (bit_cnt_q == BITS_LAST) begin
                                oe_q    <= 1'b0;
                                state_q <= ST_TX_ACK;
                            end else begin
                                oe_q <= ~tx_q[DATA_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt.scl_rise) begin
                            mack_q <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            bit_cnt_q <= '0;
                            if (mack_q && byte_idx_q == '0) begin
                                byte_idx_q <= byte_idx_q + 1'b1;
                                oe_q       <= ~tx_q[DATA_W-1];
                                state_q    <= ST_TX;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe    = oe_q;
    assign reg_addr  = ptr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;
    assign reg_re    = re_q;

endmodule

// File: rtl/i2cp_target.sv
module i2cp_target
    import i2cp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_flt;
    logic               scl_flt;
    logic               sda_flt;
    bus_evt_t           evt;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2cp_line_filter #(
            .SYNC_N (SYNC_N),
            .FILT_N (FILT_N),
            .RST_VAL(1'b1)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (line_raw[g]),
            .dout(line_flt[g])
        );
    end

    assign scl_flt = line_flt[0];
    assign sda_flt = line_flt[1];

    i2cp_bus_events u_evt (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_flt),
        .sda_f(sda_flt),
        .evt  (evt)
    );

    i2cp_xfer_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_sel (addr_sel),
        .reg_rdata(reg_rdata),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re)
    );

endmodule

// File: rtl/i2cp_checker.sv
module i2cp_checker (
    input logic        clk,
    input logic        rst,
    input logic        scl_f,
    input logic        sda_oe,
    input logic        reg_we,
    input logic        reg_re,
    input logic [15:0] reg_addr
);

    // R5: write strobe lasts a single clock
    assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R2: read strobe lasts a single clock
    assert_re_single_R2: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    // R2, R5: strobes never coincide
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    // R12: SDA drive only starts while SCL is low
    assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);

    // R5: pointer is steady while a write strobe is issued
    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $stable(reg_addr));

endmodule

bind i2cp_target i2cp_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (scl_flt),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .reg_re  (reg_re),
    .reg_addr(reg_addr)
);

// File: tb/tb_i2cp_target.sv
module tb_i2cp_target;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 12 * CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic [15:0] reg_addr, reg_wdata, reg_rdata;
    logic        reg_we, reg_re;
    logic [15:0] regs [16];
    int          we_cnt = 0;
    int          re_cnt = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    i2cp_target dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_rdata(reg_rdata)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    // register file model behind the register port
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) regs[i] <= 16'h1000 + 16'(i);
        end else if (reg_we) begin
            regs[reg_addr[3:0]] <= reg_wdata;
        end
    end
    assign reg_rdata = regs[reg_addr[3:0]];

    always @(posedge clk) begin
        if (!rst && reg_we) we_cnt <= we_cnt + 1;
        if (!rst && reg_re) re_cnt <= re_cnt + 1;
    end

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #(Q);
        scl_m = 1'b1; #(Q);
        sda_m = 1'b0; #(Q);
        scl_m = 1'b0; #(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #(Q);
        scl_m = 1'b1; #(2 * Q);
        sda_m = 1'b1; #(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; #(Q);
            scl_m = 1'b1; #(2 * Q);
            scl_m = 1'b0; #(Q);
        end
        sda_m = 1'b1; #(Q);
        scl_m = 1'b1; #(Q);
        ack = !sda_line; #(Q);
        scl_m = 1'b0; #(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #(Q);
            scl_m = 1'b1; #(Q);
            b[i] = sda_line; #(Q);
            scl_m = 1'b0; #(Q);
        end
        sda_m = !mack; #(Q);
        scl_m = 1'b1; #(2 * Q);
        scl_m = 1'b0; #(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, output int acks);
        bit ack;
        acks = 0;
        bus_start();
        send_byte(8'hE0, ack); acks += int'(ack);
        send_byte(a[15:8], ack); acks += int'(ack);
        send_byte(a[7:0], ack);  acks += int'(ack);
        send_byte(d[15:8], ack); acks += int'(ack);
        send_byte(d[7:0], ack);  acks += int'(ack);
        bus_stop();
    endtask

    task automatic do_read(output logic [15:0] d, output bit ack);
        logic [7:0] hi, lo;
        bus_start();
        send_byte(8'hE1, ack);
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        bus_stop();
        d = {hi, lo};
    endtask

    task automatic t_reset();
        check_eq("R12", "sda_oe after reset", 32'(sda_oe), 32'd0);
        check_eq("R12", "reg_addr after reset", 32'(reg_addr), 32'd0);
        check_eq("R12", "reg_we after reset", 32'(reg_we), 32'd0);
        check_eq("R12", "reg_re after reset", 32'(reg_re), 32'd0);
    endtask

    task automatic t_wrong_addr();
        bit ack;
        int w0 = we_cnt;
        bus_start();
        send_byte(8'hE2, ack);
        check_eq("R3", "nack on foreign address", 32'(ack), 32'd0);
        send_byte(8'h00, ack);
        check_eq("R3", "later byte not acked", 32'(ack), 32'd0);
        bus_stop();
        check_eq("R3", "no write after mismatch", 32'(we_cnt - w0), 32'd0);
    endtask

    task automatic t_set_ptr();
        bit a0, a1, a2;
        bus_start();
        send_byte(8'hE0, a0);
        send_byte(8'h00, a1);
        send_byte(8'h03, a2);
        bus_stop();
        check_eq("R1", "control byte acked", 32'(a0), 32'd1);
        check_eq("R4", "address bytes acked", 32'({a1, a2}), 32'd3);
        check_eq("R4", "pointer loaded", 32'(reg_addr), 32'h0003);
    endtask

    task automatic t_write();
        int acks;
        int w0 = we_cnt;
        do_write(16'h0005, 16'hBEEF, acks);
        check_eq("R5", "all write bytes acked", 32'(acks), 32'd5);
        check_eq("R5", "one write strobe", 32'(we_cnt - w0), 32'd1);
        check_eq("R5", "register written", 32'(regs[5]), 32'hBEEF);
        check_eq("R5", "pointer follows write", 32'(reg_addr), 32'h0005);
    endtask

    task automatic t_read();
        logic [15:0] d;
        bit ack;
        int r0 = re_cnt;
        do_read(d, ack);
        check_eq("R2", "read control acked", 32'(ack), 32'd1);
        check_eq("R2", "one read strobe", 32'(re_cnt - r0), 32'd1);
        check_eq("R6", "read data", 32'(d), 32'hBEEF);
    endtask

    task automatic t_persist();
        int acks;
        logic [15:0] d;
        bit ack;
        do_write(16'h0009, 16'h1234, acks);
        do_read(d, ack);
        check_eq("R7", "first read of kept pointer", 32'(d), 32'h1234);
        do_read(d, ack);
        check_eq("R7", "second read of kept pointer", 32'(d), 32'h1234);
    endtask

    task automatic t_abort();
        bit ack;
        logic [7:0] hi, lo;
        int w0 = we_cnt;
        bus_start();
        send_byte(8'hE0, ack);
        send_byte(8'h00, ack);
        send_byte(8'h07, ack);
        send_byte(8'hAA, ack);
        bus_stop();
        check_eq("R8", "stop aborts write", 32'(we_cnt - w0), 32'd0);
        bus_start();
        send_byte(8'hE0, ack);
        send_byte(8'h00, ack);
        send_byte(8'h07, ack);
        send_byte(8'h55, ack);
        bus_start();
        send_byte(8'hE1, ack);
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        bus_stop();
        check_eq("R8", "repeated start aborts write", 32'(we_cnt - w0), 32'd0);
        check_eq("R8", "register unchanged", 32'({hi, lo}), 32'h1007);
    endtask

    task automatic t_addr_sel();
        bit ack;
        int acks;
        addr_sel = 1'b1;
        #(4 * Q);
        bus_start();
        send_byte(8'hE0, ack);
        bus_stop();
        check_eq("R1", "strap 1 rejects 1110000", 32'(ack), 32'd0);
        bus_start();
        send_byte(8'hE2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h02, ack);
        send_byte(8'hA5, ack);
        send_byte(8'hC3, ack);
        bus_stop();
        check_eq("R1", "strap 1 accepts 1110001", 32'(regs[2]), 32'hA5C3);
        addr_sel = 1'b0;
        #(4 * Q);
        do_write(16'h0003, 16'h0F0F, acks);
        check_eq("R1", "strap 0 accepts 1110000", 32'(acks), 32'd5);
    endtask

    task automatic t_glitch();
        bit ack;
        int w0 = we_cnt;
        bus_start();
        send_byte(8'hE0, ack);
        send_byte(8'h00, ack);
        #(Q);
        scl_m = 1'b1; #(2 * CLK_PERIOD);
        scl_m = 1'b0; #(Q);
        sda_m = 1'b0; #(Q);
        sda_m = 1'b1; #(CLK_PERIOD);
        sda_m = 1'b0; #(2 * CLK_PERIOD);
        sda_m = 1'b1; #(Q);
        send_byte(8'h0B, ack);
        send_byte(8'h5A, ack);
        scl_m = 1'b1; #(2 * CLK_PERIOD);
        scl_m = 1'b0; #(Q);
        send_byte(8'h69, ack);
        bus_stop();
        check_eq("R9", "write through glitches", 32'(we_cnt - w0), 32'd1);
        check_eq("R9", "data through glitches", 32'(regs[11]), 32'h5A69);
    endtask

    task automatic t_nack_release();
        bit ack;
        logic [7:0] hi, nxt;
        int acks;
        do_write(16'h0005, 16'h00FF, acks);
        bus_start();
        send_byte(8'hE1, ack);
        recv_byte(1'b0, hi);
        #(2 * Q);
        check_eq("R10", "sda released after master nack", 32'(sda_oe), 32'd0);
        recv_byte(1'b0, nxt);
        bus_stop();
        check_eq("R6", "high byte read", 32'(hi), 32'h00);
        check_eq("R10", "no drive after nack", 32'(nxt), 32'hFF);
        bus_start();
        send_byte(8'hE1, ack);
        recv_byte(1'b1, hi);
        recv_byte(1'b1, hi);
        recv_byte(1'b0, nxt);
        bus_stop();
        check_eq("R10", "no drive after low byte", 32'(nxt), 32'hFF);
    endtask

    task automatic t_extra_byte();
        bit ack;
        int w0 = we_cnt;
        bus_start();
        send_byte(8'hE0, ack);
        send_byte(8'h00, ack);
        send_byte(8'h04, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        bus_stop();
        check_eq("R11", "fifth byte nacked", 32'(ack), 32'd0);
        check_eq("R11", "single strobe", 32'(we_cnt - w0), 32'd1);
        check_eq("R11", "register holds four-byte data", 32'(regs[4]), 32'h1122);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        #(CLK_PERIOD);
        t_reset();
        #(4 * Q);
        t_wrong_addr();
        t_set_ptr();
        t_write();
        t_read();
        t_persist();
        t_abort();
        t_addr_sel();
        t_glitch();
        t_nack_release();
        t_extra_byte();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule